// File: doc/BRIEF.md
# DRAM Command Spacing Checker

This block watches the decoded command stream going to a DDR2-class memory device and reports any command that arrives sooner than a minimum spacing rule allows. It sees one command per clock: an operation code, a bank index, an auto-precharge qualifier, the additive-latency setting in force and the write-recovery value programmed for auto-precharge writes. It drives no command of its own. It only observes, so it can sit beside a memory controller in simulation or in silicon as a protocol monitor.

Device timing limits are parameters in picoseconds and are converted to whole clocks by rounding up. Limits that depend on the write data burst are taken from the command's arrival, the additive latency, the CAS latency and the burst length. A per-bank pair of down-counters tracks read-to-precharge and write-recovery. Global down-counters track activate-to-activate, write-to-read and the power-down exit windows. Each rule has its own flag bit. A flag pulses for one cycle, the cycle after the offending command. A sticky error output gathers every violation.

Top module: `ddr_cmd_spacing_chk`

## Requirements
- R1: After reset, `viol_o` is all zero and `err_o` is low, and all timers are idle, so the first command of any kind raises no flag.
- R2: An activate (op 1) to a bank other than the most recently activated bank, issued fewer than ceil(tRRD/tCK) clocks after that activate, sets `viol_o[0]`. An activate to the same bank never sets this bit.
- R3: A precharge to bank b (op 4), or a precharge-all (op 7), issued fewer than ceil(tRTP/tCK) clocks after a read (op 2) to bank b sets `viol_o[1]`. A read to another bank has no effect on this check.
- R4: A precharge covering bank b (op 4 to b, or op 7) issued fewer than AL + CL - 1 + BL/2 + ceil(tWR/tCK) clocks after a write (op 3) to bank b sets `viol_o[2]`.
- R5: A read to any bank issued fewer than AL + CL - 1 + BL/2 + ceil(tWTR/tCK) clocks after any write sets `viol_o[3]`.
- R6: Any command other than NOP (op 0) or a power-down exit (op 5 fast, op 6 slow), issued fewer than TXP clocks after either exit, sets `viol_o[4]`.
- R7: A read issued fewer than XARDS_BASE - AL clocks after a slow exit (op 6) sets `viol_o[5]`. When AL >= XARDS_BASE there is no extra limit. A later fast exit cancels the window.
- R8: A write with `cmd_ap` = 1 whose `wr_cfg` is less than ceil(tWR/tCK) sets `viol_o[6]`. A write with `cmd_ap` = 0 never sets this bit.
- R9: Each flag bit is a one-cycle pulse in the cycle after the offending command. Several bits may rise together for one command.
- R10: `err_o` rises together with any flag bit and stays high until reset.
- R11: The AL value that governs a window is the one present on `al_cfg` with the write or the exit that opened it. Later changes do not move that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Operation: 0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 fast exit, 6 slow exit, 7 precharge-all |
| cmd_bank | input | BANK_W | Bank addressed by the command |
| cmd_ap | input | 1 | Auto-precharge qualifier for writes |
| al_cfg | input | AL_W | Additive latency in clocks |
| wr_cfg | input | WR_W | Write-recovery setting in clocks for auto-precharge writes |
| viol_o | output | 7 | Per-rule violation pulses, bit order as in R2 to R8 |
| err_o | output | 1 | Sticky error flag |

## Verification
On every cycle, the assertions check that each flag bit can only follow its own command type, and that an activate to the same bank is exempt from the activate spacing rule. They also check that a busy activate window or an undersized auto-precharge recovery setting does raise its bit, and that the sticky error never falls. Only the bench scenarios can show where each window ends. They place commands one clock inside and exactly at every limit, at two AL values and with AL changed mid-window, and they check that bank separation, precharge-all coverage and several bits raised by one command behave as stated.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_ACT      = 3'd1,
    OP_RD       = 3'd2,
    OP_WR       = 3'd3,
    OP_PRE      = 3'd4,
    OP_PDX_FAST = 3'd5,
    OP_PDX_SLOW = 3'd6,
    OP_PREA     = 3'd7
  } dcs_op_e;

  localparam int NUM_RULES  = 7;
  localparam int RULE_RRD   = 0;
  localparam int RULE_RTP   = 1;
  localparam int RULE_WR    = 2;
  localparam int RULE_WTR   = 3;
  localparam int RULE_XP    = 4;
  localparam int RULE_XARDS = 5;
  localparam int RULE_WRAP  = 6;

  // picoseconds to clocks, rounded up
  function automatic int ps_to_clk(input int ps, input int tck_ps);
    return (ps + tck_ps - 1) / tck_ps;
  endfunction

  // clocks from a write command to the end of its data burst
  function automatic int wdata_end(input int al, input int cl, input int bl);
    return al + cl - 1 + bl / 2;
  endfunction

  // counter load for a window of n clocks (command legal at distance >= n)
  function automatic int win_load(input int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  // read window after a slow exit
  function automatic int slow_exit_win(input int base, input int al);
    return (base > al) ? base - al : 0;
  endfunction

endpackage

// File: rtl/dcs_down_cnt.sv
module dcs_down_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/dcs_bank_timers.sv
module dcs_bank_timers #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_hit,
  input  logic         wr_hit,
  input  logic [W-1:0] rtp_load,
  input  logic [W-1:0] wr_load,
  output logic         rtp_busy,
  output logic         wr_busy
);
  dcs_down_cnt #(.W(W)) u_rtp (
    .clk(clk), .rst_n(rst_n), .load(rd_hit), .load_val(rtp_load), .busy(rtp_busy)
  );

  dcs_down_cnt #(.W(W)) u_wr (
    .clk(clk), .rst_n(rst_n), .load(wr_hit), .load_val(wr_load), .busy(wr_busy)
  );
endmodule

// File: rtl/dcs_rule_eval.sv
module dcs_rule_eval
  import dcs_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic                 is_act,
  input  logic                 act_other_bank,
  input  logic                 rrd_busy,
  input  logic [NUM_BANKS-1:0] pre_hit,
  input  logic [NUM_BANKS-1:0] rtp_busy,
  input  logic [NUM_BANKS-1:0] wr_busy,
  input  logic                 is_rd,
  input  logic                 wtr_busy,
  input  logic                 is_cmd,
  input  logic                 xp_busy,
  input  logic                 xards_busy,
  input  logic                 is_wr,
  input  logic                 cmd_ap,
  input  logic                 wrap_short,
  output logic [NUM_RULES-1:0] viol_next
);
  always_comb begin
    viol_next             = '0;
    viol_next[RULE_RRD]   = is_act & act_other_bank & rrd_busy;
    viol_next[RULE_RTP]   = |(pre_hit & rtp_busy);
    viol_next[RULE_WR]    = |(pre_hit & wr_busy);
    viol_next[RULE_WTR]   = is_rd & wtr_busy;
    viol_next[RULE_XP]    = is_cmd & xp_busy;
    viol_next[RULE_XARDS] = is_rd & xards_busy;
    viol_next[RULE_WRAP]  = is_wr & cmd_ap & wrap_short;
  end
endmodule

// File: rtl/ddr_cmd_spacing_chk.sv
module ddr_cmd_spacing_chk
  import dcs_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int AL_W        = 3,
  parameter int WR_W        = 4,
  parameter int TCK_PS      = 2500,
  parameter int TRRD_PS     = 10000,
  parameter int TRTP_PS     = 7500,
  parameter int TWR_PS      = 15000,
  parameter int TWTR_PS     = 7500,
  parameter int CL          = 4,
  parameter int BL          = 4,
  parameter int TXP         = 2,
  parameter int XARDS_BASE  = 7,
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic                 cmd_ap,
  input  logic [AL_W-1:0]      al_cfg,
  input  logic [WR_W-1:0]      wr_cfg,
  output logic [NUM_RULES-1:0] viol_o,
  output logic                 err_o
);
  localparam int TRRD_CYC = ps_to_clk(TRRD_PS, TCK_PS);
  localparam int TRTP_CYC = ps_to_clk(TRTP_PS, TCK_PS);
  localparam int TWR_CYC  = ps_to_clk(TWR_PS,  TCK_PS);
  localparam int TWTR_CYC = ps_to_clk(TWTR_PS, TCK_PS);
  localparam int AL_MAX   = (1 << AL_W) - 1;
  localparam int MAX_WIN  = wdata_end(AL_MAX, CL, BL) + TWR_CYC + TWTR_CYC
                            + TRRD_CYC + TRTP_CYC + TXP + XARDS_BASE;
  localparam int CNT_W    = $clog2(MAX_WIN + 1);
  localparam logic [WR_W-1:0] TWR_CYC_W = WR_W'(TWR_CYC);

  dcs_op_e op;
  assign op = dcs_op_e'(cmd_op);

  // decoded events
  logic is_act, is_rd, is_wr, is_pre, is_prea, is_exit, is_slow, is_cmd;
  assign is_act  = (op == OP_ACT);
  assign is_rd   = (op == OP_RD);
  assign is_wr   = (op == OP_WR);
  assign is_pre  = (op == OP_PRE);
  assign is_prea = (op == OP_PREA);
  assign is_slow = (op == OP_PDX_SLOW);
  assign is_exit = (op == OP_PDX_FAST) | is_slow;
  assign is_cmd  = (op != OP_NOP) & ~is_exit;

  // window loads, AL taken from the opening command
  int al_i;
  assign al_i = int'(al_cfg);

  logic [CNT_W-1:0] rrd_load, rtp_load, wr_load, wtr_load, xp_load, xards_load;
  assign rrd_load   = CNT_W'(win_load(TRRD_CYC));
  assign rtp_load   = CNT_W'(win_load(TRTP_CYC));
  assign wr_load    = CNT_W'(win_load(wdata_end(al_i, CL, BL) + TWR_CYC));
  assign wtr_load   = CNT_W'(win_load(wdata_end(al_i, CL, BL) + TWTR_CYC));
  assign xp_load    = CNT_W'(win_load(TXP));
  assign xards_load = is_slow ? CNT_W'(win_load(slow_exit_win(XARDS_BASE, al_i)))
                              : '0;

  // per-bank timers
  logic [NUM_BANKS-1:0] pre_hit, rtp_busy, wr_busy;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit        = (cmd_bank == BANK_W'(b));
    assign pre_hit[b] = (is_pre & hit) | is_prea;

    dcs_bank_timers #(.W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_hit   (is_rd & hit),
      .wr_hit   (is_wr & hit),
      .rtp_load (rtp_load),
      .wr_load  (wr_load),
      .rtp_busy (rtp_busy[b]),
      .wr_busy  (wr_busy[b])
    );
  end

  // global timers
  logic rrd_busy, wtr_busy, xp_busy, xards_busy;

  dcs_down_cnt #(.W(CNT_W)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(is_act), .load_val(rrd_load), .busy(rrd_busy)
  );
  dcs_down_cnt #(.W(CNT_W)) u_wtr (
    .clk(clk), .rst_n(rst_n), .load(is_wr), .load_val(wtr_load), .busy(wtr_busy)
  );
  dcs_down_cnt #(.W(CNT_W)) u_xp (
    .clk(clk), .rst_n(rst_n), .load(is_exit), .load_val(xp_load), .busy(xp_busy)
  );
  dcs_down_cnt #(.W(CNT_W)) u_xards (
    .clk(clk), .rst_n(rst_n), .load(is_exit), .load_val(xards_load), .busy(xards_busy)
  );

  // last activated bank
  logic [BANK_W-1:0] last_act_bank;
  logic              act_other_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_act_bank <= '0;
    else if (is_act) last_act_bank <= cmd_bank;
  end
  assign act_other_bank = (cmd_bank != last_act_bank);

  logic wrap_short;
  assign wrap_short = (wr_cfg < TWR_CYC_W);

  logic [NUM_RULES-1:0] viol_next;

  dcs_rule_eval #(.NUM_BANKS(NUM_BANKS)) u_eval (
    .is_act         (is_act),
    .act_other_bank (act_other_bank),
    .rrd_busy       (rrd_busy),
    .pre_hit        (pre_hit),
    .rtp_busy       (rtp_busy),
    .wr_busy        (wr_busy),
    .is_rd          (is_rd),
    .wtr_busy       (wtr_busy),
    .is_cmd         (is_cmd),
    .xp_busy        (xp_busy),
    .xards_busy     (xards_busy),
    .is_wr          (is_wr),
    .cmd_ap         (cmd_ap),
    .wrap_short     (wrap_short),
    .viol_next      (viol_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_o <= '0;
      err_o  <= 1'b0;
    end else begin
      viol_o <= viol_next;
      err_o  <= err_o | (|viol_next);
    end
  end
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker
  import dcs_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [2:0]           cmd_op,
  input logic                 cmd_ap,
  input logic [NUM_RULES-1:0] viol_o,
  input logic                 err_o,
  input logic                 rrd_busy,
  input logic                 act_other_bank,
  input logic                 wrap_short
);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  a_r10_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|viol_o) |-> err_o);

  a_r9_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd0) |=> (viol_o == '0));

  a_r2_only_act: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op != 3'd1) |=> !viol_o[RULE_RRD]);

  a_r2_same_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd1 && !act_other_bank) |=> !viol_o[RULE_RRD]);

  a_r2_busy_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd1 && act_other_bank && rrd_busy) |=> viol_o[RULE_RRD]);

  a_r3_only_pre: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_op == 3'd4 || cmd_op == 3'd7) |=> !viol_o[RULE_RTP] && !viol_o[RULE_WR]);

  a_r5_only_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op != 3'd2) |=> !viol_o[RULE_WTR] && !viol_o[RULE_XARDS]);

  a_r6_exit_exempt: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd0 || cmd_op == 3'd5 || cmd_op == 3'd6) |=> !viol_o[RULE_XP]);

  a_r8_no_ap: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_op == 3'd3 && cmd_ap) |=> !viol_o[RULE_WRAP]);

  a_r8_short: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd3 && cmd_ap && wrap_short) |=> viol_o[RULE_WRAP]);
endmodule

bind ddr_cmd_spacing_chk dcs_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_op         (cmd_op),
  .cmd_ap         (cmd_ap),
  .viol_o         (viol_o),
  .err_o          (err_o),
  .rrd_busy       (rrd_busy),
  .act_other_bank (act_other_bank),
  .wrap_short     (wrap_short)
);

// File: tb/sim_ddr_cmd_spacing_chk.sv
module sim_ddr_cmd_spacing_chk;
  localparam int TCK = 2500;
  // restated limits: ceiling of picoseconds over the clock period
  function automatic int clks(input int ps);
    return ps / TCK + ((ps % TCK) != 0 ? 1 : 0);
  endfunction
  localparam int N_RRD = clks(10000);
  localparam int N_RTP = clks(7500);
  localparam int N_WR  = clks(15000);
  localparam int N_WTR = clks(7500);
  localparam int CL = 4, BL = 4, TXP = 2, XBASE = 7;

  function automatic int wr_win(input int al);  return al + CL - 1 + BL/2 + N_WR;  endfunction
  function automatic int wtr_win(input int al); return al + CL - 1 + BL/2 + N_WTR; endfunction

  logic clk = 0, rst_n = 0;
  logic [2:0] cmd_op = 0;
  logic [2:0] cmd_bank = 0;
  logic cmd_ap = 0;
  logic [2:0] al_cfg = 0;
  logic [3:0] wr_cfg = 4'd6;
  logic [6:0] viol_o;
  logic err_o;
  logic [6:0] got;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ddr_cmd_spacing_chk u0 (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_ap(cmd_ap), .al_cfg(al_cfg), .wr_cfg(wr_cfg),
    .viol_o(viol_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cmd_op = 0; al_cfg = 0; cmd_ap = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  // drive one command, capture the flags it produced
  task automatic send(input logic [2:0] op, input logic [2:0] bank, input logic ap);
    @(negedge clk); cmd_op = op; cmd_bank = bank; cmd_ap = ap;
    @(posedge clk); #1; got = viol_o; cmd_op = 0; cmd_ap = 0;
  endtask

  // next send lands d clocks after the previous one
  task automatic gap(input int d);
    repeat (d - 1) @(posedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 flags after reset", viol_o, 7'b0);
    chk("R1 err after reset", {6'b0, err_o}, 7'b0);
    send(3'd2, 0, 0); chk("R1 first read quiet", got, 7'b0);
    send(3'd4, 1, 0); chk("R1 first precharge other bank quiet", got, 7'b0);
  endtask

  task automatic t_rrd();
    do_reset();
    send(3'd1, 0, 0);
    gap(N_RRD - 1); send(3'd1, 1, 0); chk("R2 act other bank too soon", got, 7'b0000001);
    gap(N_RRD);     send(3'd1, 2, 0); chk("R2 act at limit", got, 7'b0);
    gap(1);         send(3'd1, 2, 0); chk("R2 same bank exempt", got, 7'b0);
  endtask

  task automatic t_rtp();
    do_reset();
    send(3'd2, 1, 0); gap(N_RTP - 1); send(3'd4, 1, 0);
    chk("R3 pre after read too soon", got, 7'b0000010);
    send(3'd2, 1, 0); gap(1); send(3'd4, 2, 0);
    chk("R3 other bank unaffected", got, 7'b0);
    gap(N_RTP); send(3'd2, 3, 0); gap(N_RTP); send(3'd4, 3, 0);
    chk("R3 pre at limit", got, 7'b0);
    gap(N_RTP); send(3'd2, 5, 0); gap(1); send(3'd7, 0, 0);
    chk("R3 precharge-all covers bank", got, 7'b0000010);
  endtask

  task automatic t_wr();
    do_reset();
    send(3'd3, 0, 0); gap(wr_win(0) - 1); send(3'd4, 0, 0);
    chk("R4 pre inside write recovery", got, 7'b0000100);
    send(3'd3, 0, 0); gap(wr_win(0)); send(3'd4, 0, 0);
    chk("R4 pre at limit", got, 7'b0);
    al_cfg = 2; send(3'd3, 1, 0); al_cfg = 0;
    gap(wr_win(0) + 1); send(3'd4, 1, 0);
    chk("R11 R4 AL from write command kept", got, 7'b0000100);
    al_cfg = 2; send(3'd3, 2, 0); al_cfg = 0;
    gap(wr_win(2)); send(3'd7, 0, 0);
    chk("R4 precharge-all at AL limit", got, 7'b0);
  endtask

  task automatic t_wtr();
    do_reset();
    send(3'd3, 0, 0); gap(wtr_win(0) - 1); send(3'd2, 1, 0);
    chk("R5 read inside write-to-read", got, 7'b0001000);
    send(3'd3, 0, 0); gap(wtr_win(0)); send(3'd2, 4, 0);
    chk("R5 read at limit", got, 7'b0);
  endtask

  task automatic t_xp();
    do_reset();
    send(3'd5, 0, 0); gap(1); send(3'd1, 0, 0);
    chk("R6 act right after fast exit", got, 7'b0010000);
    gap(N_RRD); send(3'd5, 0, 0); gap(TXP); send(3'd1, 1, 0);
    chk("R6 act at limit", got, 7'b0);
    send(3'd6, 0, 0); gap(1); send(3'd4, 2, 0);
    chk("R6 pre right after slow exit", got, 7'b0010000);
  endtask

  task automatic t_xards();
    do_reset();
    send(3'd6, 0, 0); gap(XBASE - 1); send(3'd2, 0, 0);
    chk("R7 read early after slow exit AL0", got, 7'b0100000);
    send(3'd6, 0, 0); gap(XBASE); send(3'd2, 0, 0);
    chk("R7 read at limit AL0", got, 7'b0);
    al_cfg = 2;
    send(3'd6, 0, 0); gap(XBASE - 2 - 1); send(3'd2, 0, 0);
    chk("R7 read early AL2", got, 7'b0100000);
    send(3'd6, 0, 0); gap(XBASE - 2); send(3'd2, 0, 0);
    chk("R7 read at limit AL2", got, 7'b0);
    al_cfg = 7;
    send(3'd6, 0, 0); gap(TXP); send(3'd2, 0, 0);
    chk("R7 no limit when AL reaches base", got, 7'b0);
    al_cfg = 0;
    send(3'd6, 0, 0); gap(1); send(3'd5, 0, 0); gap(TXP); send(3'd2, 0, 0);
    chk("R7 fast exit cancels slow window", got, 7'b0);
  endtask

  task automatic t_wrap();
    do_reset();
    wr_cfg = 4'(N_WR - 1); send(3'd3, 0, 1);
    chk("R8 short recovery with auto-precharge", got, 7'b1000000);
    send(3'd3, 1, 0);
    chk("R8 plain write ignores setting", got, 7'b0);
    wr_cfg = 4'(N_WR); send(3'd3, 2, 1);
    chk("R8 recovery setting at limit", got, 7'b0);
  endtask

  task automatic t_multi_sticky();
    do_reset();
    al_cfg = 0;
    send(3'd6, 0, 0); gap(1); send(3'd2, 0, 0);
    chk("R9 two bits from one read", got, 7'b0110000);
    @(posedge clk); #1;
    chk("R9 pulse lasts one cycle", viol_o, 7'b0);
    chk("R10 err set", {6'b0, err_o}, 7'b1);
    repeat (20) @(posedge clk); #1;
    chk("R10 err held", {6'b0, err_o}, 7'b1);
    do_reset(); #1;
    chk("R10 err cleared by reset", {6'b0, err_o}, 7'b0);
  endtask

  initial begin
    t_reset();
    t_rrd();
    t_rtp();
    t_wr();
    t_wtr();
    t_xp();
    t_xards();
    t_wrap();
    t_multi_sticky();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule